// File: doc/BRIEF.md
# ASID-Tagged Fully Associative Translation Buffer

This block is a first-level address translation cache for a 32-bit virtual address space. It holds a parameterised number of entries (32 by default), any of which can hold any mapping. A lookup presents a virtual address, the current 8-bit address space identifier, an access kind (read, write, execute) and a privilege flag. One cycle after the lookup is accepted, the block returns a hit flag, the translated physical address and a fault code. A miss raises a request toward the next translation level.

New mappings arrive on a refill port from a table walker or a second-level buffer. The walker and the second level are not part of this block. Control pins invalidate everything, every non-global entry of one identifier, or every entry whose page covers a given address. A lock port pins entries so that replacement never picks them. The domain check reads a 32-bit domain access control word that enters on a pin.

Lookup and response form a valid/ready pair. A response is held while `rs_ready` is low, and `lk_ready` is low whenever a held response has not yet been taken. The refill port never applies back-pressure: `rf_ready` is always high, and a refill with no replaceable entry is dropped and reported.

Top module: `xlat_cache`

## Requirements
- R1: After reset no entry is valid, `rs_valid` is low and `lk_ready` is high. A lookup accepted at a clock edge (`lk_valid && lk_ready`) gives `rs_valid` after that edge. On a hit, the response carries the physical address of the lowest-indexed matching entry.
- R2: The refill size code selects the page size: 00 is 4 KB, 01 is 64 KB, 10 is 1 MB, and 11 is treated as 4 KB. The tag compare ignores the virtual address bits below the page size. The physical address takes the entry's frame bits above the page size and the lookup address bits below it.
- R3: A non-global entry matches only when its identifier equals `lk_asid`. A global entry matches under any identifier.
- R4: On a miss, `rs_hit`, `rs_fault` and `rs_pa` are zero. `miss_req` is high while the response is valid, with `miss_va`/`miss_asid` equal to the looked-up values.
- R5: An entry's 4-bit domain `d` selects `dacr[2d+1:2d]`. The values 00 and 10 give a domain fault, fault code 01.
- R6: A domain field of 11 (manager) allows every access and ignores both the permission bits and execute-never.
- R7: For a domain field of 01 (client), the 2-bit permission code controls access. Code 00 allows privileged read/write and no user access. Code 01 allows privileged read/write and user read. Code 10 allows read/write at both levels. Code 11 allows read only at both levels. A denied access gives fault code 10.
- R8: Access codes are 00 read, 01 write and 10 execute. Under client, an execute of an execute-never entry gives fault code 11; otherwise an execute needs read permission. Domain faults take priority over execute-never faults, and execute-never faults take priority over permission faults. A faulting response has `rs_hit` high and `rs_pa` zero.
- R9: `inv_op` 01 clears all entries. `inv_op` 10 clears only non-global entries whose identifier equals `inv_asid`. `inv_op` 11 clears every entry, of any identifier, whose page covers `inv_va`.
- R10: A refill writes the first unlocked entry at or after a round-robin pointer, and the pointer then moves to the entry after the one written. A locked entry is never overwritten by a refill.
- R11: When every entry is locked, a refill is dropped and `fill_ovf` pulses high for the cycle after it.
- R12: In one cycle, the invalidate is applied first and the refill write second, so a refilled entry survives an invalidate in the same cycle. A lookup sees the table as it was before that cycle's refill.
- R13: While `rs_valid` is high and `rs_ready` low, the response is held unchanged and `lk_ready` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request valid |
| lk_ready | output | 1 | Lookup can be accepted |
| lk_va | input | 32 | Lookup virtual address |
| lk_asid | input | 8 | Current address space identifier |
| lk_acc | input | 2 | Access kind: 00 read, 01 write, 10 execute |
| lk_priv | input | 1 | Privileged access |
| dacr | input | 32 | Domain access control word, 2 bits per domain |
| rs_valid | output | 1 | Response valid |
| rs_ready | input | 1 | Response taken |
| rs_hit | output | 1 | A matching entry was found |
| rs_pa | output | 32 | Physical address, zero on miss or fault |
| rs_fault | output | 2 | 00 none, 01 domain, 10 permission, 11 execute-never |
| miss_req | output | 1 | Miss request to the next level |
| miss_va | output | 32 | Address of the missed lookup |
| miss_asid | output | 8 | Identifier of the missed lookup |
| rf_valid | input | 1 | Refill valid |
| rf_ready | output | 1 | Refill accepted (always high) |
| rf_va | input | 32 | Refill virtual page address |
| rf_pa | input | 32 | Refill physical frame address |
| rf_size | input | 2 | Page size code |
| rf_asid | input | 8 | Entry identifier |
| rf_global | input | 1 | Entry is global |
| rf_dom | input | 4 | Entry domain number |
| rf_ap | input | 2 | Entry permission code |
| rf_xn | input | 1 | Entry execute-never |
| inv_op | input | 2 | 00 none, 01 all, 10 by identifier, 11 by address |
| inv_va | input | 32 | Address for invalidate by address |
| inv_asid | input | 8 | Identifier for invalidate by identifier |
| lock_we | input | 1 | Lock bit write enable |
| lock_idx | input | 5 | Entry index for the lock write |
| lock_set | input | 1 | New lock bit value |
| fill_ovf | output | 1 | Refill dropped because every entry is locked |

## Verification
Two pairs of functions can fall in the same clock cycle, and both pairs are driven together deliberately. First, a global-entry invalidate-all and a refill of a new page are asserted on one edge. The bench then expects the old page to miss and the new page to hit. Second, a lookup and the refill of the very page being looked up are accepted on one edge. The scoreboard expects that response to be a miss, and a lookup issued afterwards to hit with the refilled frame.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
  localparam int VA_W   = 32;
  localparam int PG_LSB = 12;
  localparam int VPN_W  = VA_W - PG_LSB;
  localparam int ASID_W = 8;
  localparam int DOM_W  = 4;

  typedef enum logic [1:0] {SZ_4K = 2'b00, SZ_64K = 2'b01, SZ_1M = 2'b10, SZ_RSV = 2'b11} pg_sz_e;
  typedef enum logic [1:0] {ACC_RD = 2'b00, ACC_WR = 2'b01, ACC_EX = 2'b10, ACC_RSV = 2'b11} acc_e;
  typedef enum logic [1:0] {FLT_NONE = 2'b00, FLT_DOM = 2'b01, FLT_PERM = 2'b10, FLT_XN = 2'b11} flt_e;
  typedef enum logic [1:0] {INV_NOP = 2'b00, INV_ALL = 2'b01, INV_ASID = 2'b10, INV_ADDR = 2'b11} inv_e;

  typedef struct packed {
    logic              vld;
    logic [VPN_W-1:0]  vpn;
    logic [VPN_W-1:0]  ppn;
    pg_sz_e            sz;
    logic [ASID_W-1:0] asid;
    logic              glb;
    logic [DOM_W-1:0]  dom;
    logic [1:0]        ap;
    logic              xn;
  } xent_t;

  // Bits of the page number that take part in the tag compare.
  function automatic logic [VPN_W-1:0] pg_mask(pg_sz_e sz);
    case (sz)
      SZ_64K:  pg_mask = {{(VPN_W-4){1'b1}}, 4'h0};
      SZ_1M:   pg_mask = {{(VPN_W-8){1'b1}}, 8'h00};
      default: pg_mask = {VPN_W{1'b1}};
    endcase
  endfunction
endpackage

// File: rtl/xlat_way_cmp.sv
module xlat_way_cmp
  import xlat_pkg::*;
(
  input  xent_t             ent,
  input  logic [VA_W-1:0]   lk_va,
  input  logic [ASID_W-1:0] lk_asid,
  input  logic [VA_W-1:0]   inv_va,
  input  logic [ASID_W-1:0] inv_asid,
  output logic              lk_hit,
  output logic              inv_addr_hit,
  output logic              inv_asid_hit
);
  logic [VPN_W-1:0] mask;
  logic             lk_addr_eq;

  always_comb begin
    mask         = pg_mask(ent.sz);
    lk_addr_eq   = ((lk_va[VA_W-1:PG_LSB] ^ ent.vpn) & mask) == '0;
    lk_hit       = ent.vld && lk_addr_eq && (ent.glb || (ent.asid == lk_asid));
    inv_addr_hit = ent.vld && (((inv_va[VA_W-1:PG_LSB] ^ ent.vpn) & mask) == '0);
    inv_asid_hit = ent.vld && !ent.glb && (ent.asid == inv_asid);
  end
endmodule

// File: rtl/xlat_victim.sv
module xlat_victim #(
  parameter int N_ENT = 32,
  parameter int IDX_W = $clog2(N_ENT)
) (
  input  logic [N_ENT-1:0] locked,
  input  logic [IDX_W-1:0] ptr,
  output logic [IDX_W-1:0] victim,
  output logic             all_locked
);
  always_comb begin
    logic found;
    found  = 1'b0;
    victim = ptr;
    for (int k = 0; k < N_ENT; k++) begin
      int unsigned j;
      j = (int'(ptr) + k) % N_ENT;
      if (!found && !locked[j]) begin
        victim = IDX_W'(j);
        found  = 1'b1;
      end
    end
    all_locked = &locked;
  end
endmodule

// File: rtl/xlat_guard.sv
module xlat_guard
  import xlat_pkg::*;
(
  input  xent_t       ent,
  input  acc_e        acc,
  input  logic        priv,
  input  logic [31:0] dacr,
  output flt_e        flt
);
  logic [1:0] dfield;
  logic       rd_ok, wr_ok;

  always_comb begin
    dfield = dacr[{ent.dom, 1'b0} +: 2];
    case (ent.ap)
      2'b00:   begin rd_ok = priv; wr_ok = priv; end
      2'b01:   begin rd_ok = 1'b1; wr_ok = priv; end
      2'b10:   begin rd_ok = 1'b1; wr_ok = 1'b1; end
      default: begin rd_ok = 1'b1; wr_ok = 1'b0; end
    endcase
    if (dfield == 2'b00 || dfield == 2'b10)      flt = FLT_DOM;
    else if (dfield == 2'b11)                    flt = FLT_NONE;
    else if (acc == ACC_EX && ent.xn)            flt = FLT_XN;
    else if (acc == ACC_WR ? !wr_ok : !rd_ok)    flt = FLT_PERM;
    else                                         flt = FLT_NONE;
  end
endmodule

// File: rtl/xlat_cache.sv
module xlat_cache
  import xlat_pkg::*;
#(
  parameter int N_ENT = 32,
  parameter int IDX_W = $clog2(N_ENT)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lk_valid,
  output logic              lk_ready,
  input  logic [VA_W-1:0]   lk_va,
  input  logic [ASID_W-1:0] lk_asid,
  input  logic [1:0]        lk_acc,
  input  logic              lk_priv,
  input  logic [31:0]       dacr,
  output logic              rs_valid,
  input  logic              rs_ready,
  output logic              rs_hit,
  output logic [VA_W-1:0]   rs_pa,
  output logic [1:0]        rs_fault,
  output logic              miss_req,
  output logic [VA_W-1:0]   miss_va,
  output logic [ASID_W-1:0] miss_asid,
  input  logic              rf_valid,
  output logic              rf_ready,
  input  logic [VA_W-1:0]   rf_va,
  input  logic [VA_W-1:0]   rf_pa,
  input  logic [1:0]        rf_size,
  input  logic [ASID_W-1:0] rf_asid,
  input  logic              rf_global,
  input  logic [DOM_W-1:0]  rf_dom,
  input  logic [1:0]        rf_ap,
  input  logic              rf_xn,
  input  logic [1:0]        inv_op,
  input  logic [VA_W-1:0]   inv_va,
  input  logic [ASID_W-1:0] inv_asid,
  input  logic              lock_we,
  input  logic [IDX_W-1:0]  lock_idx,
  input  logic              lock_set,
  output logic              fill_ovf
);
  xent_t              tbl_q [N_ENT];
  logic [N_ENT-1:0]   lock_q;
  logic [IDX_W-1:0]   ptr_q;
  logic [N_ENT-1:0]   lk_hit_v, inv_a_v, inv_s_v, kill_v;
  logic [IDX_W-1:0]   hit_idx, vic_idx;
  logic               any_hit, all_lk, fill_ok, lk_fire;
  xent_t              sel_ent, new_ent;
  flt_e               chk_flt;
  logic [VPN_W-1:0]   sel_mask;
  logic [VA_W-1:0]    comp_pa;

  logic               rs_valid_q, rs_hit_q, ovf_q;
  logic [VA_W-1:0]    rs_pa_q, rs_va_q;
  logic [1:0]         rs_flt_q;
  logic [ASID_W-1:0]  rs_asid_q;

  // One compare unit per entry: lookup match and both invalidate matches.
  for (genvar g = 0; g < N_ENT; g++) begin : g_way
    xlat_way_cmp u_cmp (
      .ent          (tbl_q[g]),
      .lk_va        (lk_va),
      .lk_asid      (lk_asid),
      .inv_va       (inv_va),
      .inv_asid     (inv_asid),
      .lk_hit       (lk_hit_v[g]),
      .inv_addr_hit (inv_a_v[g]),
      .inv_asid_hit (inv_s_v[g])
    );
  end

  // Lowest matching index wins.
  always_comb begin
    hit_idx = '0;
    any_hit = 1'b0;
    for (int i = N_ENT - 1; i >= 0; i--) begin
      if (lk_hit_v[i]) begin
        hit_idx = IDX_W'(i);
        any_hit = 1'b1;
      end
    end
  end

  assign sel_ent = tbl_q[hit_idx];

  xlat_guard u_guard (
    .ent  (sel_ent),
    .acc  (acc_e'(lk_acc)),
    .priv (lk_priv),
    .dacr (dacr),
    .flt  (chk_flt)
  );

  always_comb begin
    sel_mask = pg_mask(sel_ent.sz);
    comp_pa  = {(sel_ent.ppn & sel_mask) | (lk_va[VA_W-1:PG_LSB] & ~sel_mask),
                lk_va[PG_LSB-1:0]};
  end

  xlat_victim #(.N_ENT(N_ENT), .IDX_W(IDX_W)) u_vic (
    .locked     (lock_q),
    .ptr        (ptr_q),
    .victim     (vic_idx),
    .all_locked (all_lk)
  );

  assign rf_ready = 1'b1;
  assign fill_ok  = rf_valid && !all_lk;

  always_comb begin
    new_ent.vld  = 1'b1;
    new_ent.vpn  = rf_va[VA_W-1:PG_LSB];
    new_ent.ppn  = rf_pa[VA_W-1:PG_LSB];
    new_ent.sz   = pg_sz_e'(rf_size);
    new_ent.asid = rf_asid;
    new_ent.glb  = rf_global;
    new_ent.dom  = rf_dom;
    new_ent.ap   = rf_ap;
    new_ent.xn   = rf_xn;
    case (inv_e'(inv_op))
      INV_ALL:  kill_v = '1;
      INV_ASID: kill_v = inv_s_v;
      INV_ADDR: kill_v = inv_a_v;
      default:  kill_v = '0;
    endcase
  end

  // Table: invalidate first, then the refill write overrides.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < N_ENT; i++) tbl_q[i] <= '0;
      lock_q <= '0;
      ptr_q  <= '0;
      ovf_q  <= 1'b0;
    end else begin
      for (int i = 0; i < N_ENT; i++) begin
        if (fill_ok && vic_idx == IDX_W'(i)) tbl_q[i] <= new_ent;
        else if (kill_v[i])                  tbl_q[i].vld <= 1'b0;
      end
      if (lock_we) lock_q[lock_idx] <= lock_set;
      if (fill_ok) ptr_q <= (vic_idx == IDX_W'(N_ENT - 1)) ? '0 : vic_idx + 1'b1;
      ovf_q <= rf_valid && all_lk;
    end
  end

  assign lk_ready = !rs_valid_q || rs_ready;
  assign lk_fire  = lk_valid && lk_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rs_valid_q <= 1'b0;
      rs_hit_q   <= 1'b0;
      rs_pa_q    <= '0;
      rs_flt_q   <= '0;
      rs_va_q    <= '0;
      rs_asid_q  <= '0;
    end else if (lk_fire) begin
      rs_valid_q <= 1'b1;
      rs_hit_q   <= any_hit;
      rs_flt_q   <= any_hit ? chk_flt : FLT_NONE;
      rs_pa_q    <= (any_hit && chk_flt == FLT_NONE) ? comp_pa : '0;
      rs_va_q    <= lk_va;
      rs_asid_q  <= lk_asid;
    end else if (rs_ready) begin
      rs_valid_q <= 1'b0;
    end
  end

  assign rs_valid  = rs_valid_q;
  assign rs_hit    = rs_hit_q;
  assign rs_pa     = rs_pa_q;
  assign rs_fault  = rs_flt_q;
  assign miss_req  = rs_valid_q && !rs_hit_q;
  assign miss_va   = rs_va_q;
  assign miss_asid = rs_asid_q;
  assign fill_ovf  = ovf_q;
endmodule

// File: rtl/xlat_cache_chk.sv
module xlat_cache_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        lk_valid,
  input logic        lk_ready,
  input logic        rf_valid,
  input logic        rs_valid,
  input logic        rs_ready,
  input logic        rs_hit,
  input logic [31:0] rs_pa,
  input logic [1:0]  rs_fault,
  input logic        miss_req,
  input logic        fill_ovf
);
  // R1: an accepted lookup yields a response on the next cycle
  a_r1_resp_follows: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid && lk_ready |=> rs_valid);

  // R8: a faulting response is a hit with no address
  a_r8_fault_no_pa: assert property (@(posedge clk) disable iff (!rst_n)
    rs_valid && rs_fault != 2'b00 |-> rs_hit && rs_pa == 32'h0);

  // R4: a miss carries no fault, no address, and raises the request
  a_r4_miss_clean: assert property (@(posedge clk) disable iff (!rst_n)
    rs_valid && !rs_hit |-> rs_fault == 2'b00 && rs_pa == 32'h0 && miss_req);

  // R13: a stalled response holds
  a_r13_hold: assert property (@(posedge clk) disable iff (!rst_n)
    rs_valid && !rs_ready |=> rs_valid && $stable(rs_pa) && $stable(rs_fault) && $stable(rs_hit));

  // R11: overflow only follows a refill attempt
  a_r11_ovf_src: assert property (@(posedge clk) disable iff (!rst_n)
    fill_ovf |-> $past(rf_valid));
endmodule

bind xlat_cache xlat_cache_chk i_xlat_cache_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .lk_valid (lk_valid),
  .lk_ready (lk_ready),
  .rf_valid (rf_valid),
  .rs_valid (rs_valid),
  .rs_ready (rs_ready),
  .rs_hit   (rs_hit),
  .rs_pa    (rs_pa),
  .rs_fault (rs_fault),
  .miss_req (miss_req),
  .fill_ovf (fill_ovf)
);

// File: tb/test_xlat_cache.sv
`timescale 1ns/1ps
module test_xlat_cache;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        lk_valid = 1'b0, lk_priv = 1'b0, rs_ready = 1'b1;
  logic        lk_ready, rs_valid, rs_hit, miss_req, rf_ready, fill_ovf;
  logic [31:0] lk_va = '0, dacr = 32'h0000_0055, rs_pa, miss_va;
  logic [7:0]  lk_asid = '0, miss_asid;
  logic [1:0]  lk_acc = '0, rs_fault;
  logic        rf_valid = 1'b0, rf_global = 1'b0, rf_xn = 1'b0;
  logic [31:0] rf_va = '0, rf_pa = '0, inv_va = '0;
  logic [1:0]  rf_size = '0, rf_ap = '0, inv_op = '0;
  logic [7:0]  rf_asid = '0, inv_asid = '0;
  logic [3:0]  rf_dom = '0;
  logic        lock_we = 1'b0, lock_set = 1'b0;
  logic [4:0]  lock_idx = '0;

  always #2.5 clk = ~clk;

  xlat_cache i_xlat_cache (.*);

  typedef struct {
    logic        hit;
    logic [31:0] pa;
    logic [1:0]  flt;
    logic [31:0] va;
    logic        care;
    string       tag;
  } exp_t;

  exp_t sbq[$];
  int   n_chk = 0, n_bad = 0;
  logic last_hit;
  bit   done = 1'b0;

  task automatic ck(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // Monitor: pop and compare each delivered response.
  always @(negedge clk) begin
    if (rst_n && rs_valid && rs_ready) begin
      last_hit = rs_hit;
      if (sbq.size() == 0) ck("R1 unexpected response", 1, 0);
      else begin
        exp_t e;
        e = sbq.pop_front();
        if (e.care) begin
          ck(e.tag, {29'h0, rs_hit, rs_fault, rs_pa}, {29'h0, e.hit, e.flt, e.pa});
          if (!e.hit) ck({e.tag, " R4 miss request"}, {31'h0, miss_req, miss_va}, {31'h0, 1'b1, e.va});
        end
      end
    end
  end

  task automatic push(input logic [31:0] va, input logic care, input logic eh,
                      input logic [31:0] epa, input logic [1:0] ef, input string tag);
    exp_t e;
    e.hit = eh; e.pa = epa; e.flt = ef; e.va = va; e.care = care; e.tag = tag;
    sbq.push_back(e);
  endtask

  task automatic drive_lk(input logic [31:0] va, input logic [7:0] asid,
                          input logic [1:0] acc, input logic priv);
    lk_valid = 1'b1; lk_va = va; lk_asid = asid; lk_acc = acc; lk_priv = priv;
  endtask

  task automatic lk(input logic [31:0] va, input logic [7:0] asid, input logic [1:0] acc,
                    input logic priv, input logic care, input logic eh,
                    input logic [31:0] epa, input logic [1:0] ef, input string tag);
    @(negedge clk);
    drive_lk(va, asid, acc, priv);
    push(va, care, eh, epa, ef, tag);
    @(negedge clk);
    lk_valid = 1'b0;
    #1;
  endtask

  task automatic set_rf(input logic [31:0] va, input logic [31:0] pa, input logic [1:0] sz,
                        input logic [7:0] asid, input logic glb, input logic [3:0] dom,
                        input logic [1:0] ap, input logic xn);
    rf_valid = 1'b1; rf_va = va; rf_pa = pa; rf_size = sz; rf_asid = asid;
    rf_global = glb; rf_dom = dom; rf_ap = ap; rf_xn = xn;
  endtask

  task automatic rf(input logic [31:0] va, input logic [31:0] pa, input logic [1:0] sz,
                    input logic [7:0] asid, input logic glb, input logic [3:0] dom,
                    input logic [1:0] ap, input logic xn);
    @(negedge clk);
    set_rf(va, pa, sz, asid, glb, dom, ap, xn);
    @(negedge clk);
    rf_valid = 1'b0;
    #1;
  endtask

  task automatic inv(input logic [1:0] op, input logic [31:0] va, input logic [7:0] asid);
    @(negedge clk);
    inv_op = op; inv_va = va; inv_asid = asid;
    @(negedge clk);
    inv_op = 2'b00;
    #1;
  endtask

  task automatic lock(input int idx, input logic val);
    @(negedge clk);
    lock_we = 1'b1; lock_idx = 5'(idx); lock_set = val;
    @(negedge clk);
    lock_we = 1'b0;
    #1;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      ck("watchdog expired", 1, 0);
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1 reset state
    ck("R1 reset rs_valid", {63'h0, rs_valid}, 0);
    ck("R1 reset lk_ready", {63'h0, lk_ready}, 1);
    ck("R11 reset fill_ovf", {63'h0, fill_ovf}, 0);
    lk(32'h0001_2ABC, 8'd5, 2'b00, 1'b0, 1, 0, 0, 0, "R1 empty after reset");

    // Fill pages
    rf(32'h0001_2000, 32'h8001_2000, 2'b00, 8'd5, 1'b0, 4'd0, 2'b10, 1'b0); // A
    rf(32'h0034_0000, 32'h9000_F000, 2'b01, 8'd0, 1'b1, 4'd0, 2'b10, 1'b0); // B 64K
    rf(32'h1230_0000, 32'hABCF_F000, 2'b10, 8'd5, 1'b0, 4'd3, 2'b00, 1'b0); // C 1M
    rf(32'h0005_0000, 32'h0077_7000, 2'b00, 8'd0, 1'b1, 4'd1, 2'b10, 1'b1); // D xn
    rf(32'h0006_0000, 32'h0088_8000, 2'b00, 8'd0, 1'b1, 4'd0, 2'b01, 1'b0); // E
    rf(32'h0007_0000, 32'h0099_9000, 2'b00, 8'd0, 1'b1, 4'd0, 2'b11, 1'b0); // F
    rf(32'h0008_0000, 32'h00AB_C000, 2'b00, 8'd7, 1'b0, 4'd0, 2'b10, 1'b0); // G

    lk(32'h0001_2ABC, 8'd5, 2'b00, 1'b0, 1, 1, 32'h8001_2ABC, 2'b00, "R1 4K hit");
    lk(32'h0001_2ABC, 8'd6, 2'b00, 1'b0, 1, 0, 0, 0, "R3 other ASID misses");
    lk(32'h0034_5678, 8'd9, 2'b00, 1'b0, 1, 1, 32'h9000_5678, 2'b00, "R2 R3 64K global");
    lk(32'h0035_0000, 8'd9, 2'b00, 1'b0, 1, 0, 0, 0, "R2 64K boundary miss");
    lk(32'h123F_FFFC, 8'd5, 2'b00, 1'b1, 1, 1, 32'hABCF_FFFC, 2'b00, "R2 1M hit");
    lk(32'h1240_0000, 8'd5, 2'b00, 1'b1, 1, 0, 0, 0, "R2 1M boundary miss");
    lk(32'h123F_FFFC, 8'd5, 2'b00, 1'b0, 1, 1, 0, 2'b10, "R7 ap00 user read");
    dacr = 32'h0000_0015;
    lk(32'h123F_FFFC, 8'd5, 2'b00, 1'b1, 1, 1, 0, 2'b01, "R5 domain 00");
    dacr = 32'h0000_0095;
    lk(32'h123F_FFFC, 8'd5, 2'b00, 1'b1, 1, 1, 0, 2'b01, "R5 domain 10");
    dacr = 32'h0000_00D5;
    lk(32'h123F_FFFC, 8'd5, 2'b01, 1'b0, 1, 1, 32'hABCF_FFFC, 2'b00, "R6 manager user write");
    dacr = 32'h0000_0055;
    lk(32'h0005_0010, 8'd1, 2'b10, 1'b0, 1, 1, 0, 2'b11, "R8 xn exec");
    lk(32'h0005_0010, 8'd1, 2'b00, 1'b0, 1, 1, 32'h0077_7010, 2'b00, "R8 xn read ok");
    dacr = 32'h0000_005D;
    lk(32'h0005_0010, 8'd1, 2'b10, 1'b0, 1, 1, 32'h0077_7010, 2'b00, "R6 manager ignores xn");
    dacr = 32'h0000_0051;
    lk(32'h0005_0010, 8'd1, 2'b10, 1'b0, 1, 1, 0, 2'b01, "R8 domain before xn");
    dacr = 32'h0000_0055;
    lk(32'h0006_0004, 8'd1, 2'b01, 1'b0, 1, 1, 0, 2'b10, "R7 ap01 user write");
    lk(32'h0006_0004, 8'd1, 2'b00, 1'b0, 1, 1, 32'h0088_8004, 2'b00, "R7 ap01 user read");
    lk(32'h0006_0004, 8'd1, 2'b01, 1'b1, 1, 1, 32'h0088_8004, 2'b00, "R7 ap01 priv write");
    lk(32'h0007_0008, 8'd1, 2'b01, 1'b1, 1, 1, 0, 2'b10, "R7 ap11 priv write");
    lk(32'h0007_0008, 8'd1, 2'b00, 1'b0, 1, 1, 32'h0099_9008, 2'b00, "R7 ap11 user read");
    lk(32'h0007_0008, 8'd1, 2'b10, 1'b0, 1, 1, 32'h0099_9008, 2'b00, "R8 exec needs read");

    // R9 invalidates
    inv(2'b10, 32'h0, 8'd5);
    lk(32'h0001_2ABC, 8'd5, 2'b00, 1'b0, 1, 0, 0, 0, "R9 asid inval removes A");
    lk(32'h123F_FFFC, 8'd5, 2'b00, 1'b1, 1, 0, 0, 0, "R9 asid inval removes C");
    lk(32'h0034_5678, 8'd5, 2'b00, 1'b0, 1, 1, 32'h9000_5678, 2'b00, "R9 global survives");
    lk(32'h0008_0000, 8'd7, 2'b00, 1'b0, 1, 1, 32'h00AB_C000, 2'b00, "R9 other asid survives");
    inv(2'b11, 32'h0034_1234, 8'd0);
    lk(32'h0034_5678, 8'd5, 2'b00, 1'b0, 1, 0, 0, 0, "R9 addr inval removes B");
    lk(32'h0005_0000, 8'd5, 2'b00, 1'b0, 1, 1, 32'h0077_7000, 2'b00, "R9 addr inval keeps D");
    inv(2'b01, 32'h0, 8'd0);
    lk(32'h0005_0000, 8'd5, 2'b00, 1'b0, 1, 0, 0, 0, "R9 inval all");

    // R13 back-pressure
    @(negedge clk);
    rs_ready = 1'b0;
    rf_valid = 1'b0;
    drive_lk(32'h0009_0000, 8'd1, 2'b00, 1'b0);
    push(32'h0009_0000, 1, 0, 0, 0, "R13 held response");
    @(negedge clk);
    lk_valid = 1'b0;
    #1;
    ck("R13 lk_ready low", {63'h0, lk_ready}, 0);
    repeat (2) @(negedge clk);
    #1;
    ck("R13 still valid", {63'h0, rs_valid}, 1);
    ck("R13 still miss", {62'h0, rs_hit, miss_req}, {62'h0, 1'b0, 1'b1});
    @(posedge clk);
    #1;
    rs_ready = 1'b1;
    @(negedge clk);
    #1;

    // R12 same-cycle invalidate and refill
    rf(32'h0010_0000, 32'h0020_0000, 2'b00, 8'd0, 1'b1, 4'd0, 2'b10, 1'b0);
    @(negedge clk);
    inv_op = 2'b01;
    set_rf(32'h0011_0000, 32'h0022_0000, 2'b00, 8'd0, 1'b1, 4'd0, 2'b10, 1'b0);
    @(negedge clk);
    inv_op = 2'b00; rf_valid = 1'b0;
    #1;
    lk(32'h0010_0040, 8'd0, 2'b00, 1'b0, 1, 0, 0, 0, "R12 old entry gone");
    lk(32'h0011_0040, 8'd0, 2'b00, 1'b0, 1, 1, 32'h0022_0040, 2'b00, "R12 refill survives inval");
    // R12 same-cycle lookup and refill
    @(negedge clk);
    drive_lk(32'h0012_0100, 8'd0, 2'b00, 1'b0);
    push(32'h0012_0100, 1, 0, 0, 0, "R12 lookup sees old table");
    set_rf(32'h0012_0000, 32'h0033_0000, 2'b00, 8'd0, 1'b1, 4'd0, 2'b10, 1'b0);
    @(negedge clk);
    lk_valid = 1'b0; rf_valid = 1'b0;
    #1;
    lk(32'h0012_0100, 8'd0, 2'b00, 1'b0, 1, 1, 32'h0033_0100, 2'b00, "R12 later lookup hits");

    // R10 / R11 replacement and locking
    inv(2'b01, 32'h0, 8'd0);
    for (int k = 0; k < 32; k++)
      rf(32'h4000_0000 + (k << 12), 32'h5000_0000 + (k << 12), 2'b00, 8'd0, 1'b1, 4'd0, 2'b10, 1'b0);
    for (int k = 0; k < 32; k++) lock(k, 1'b1);
    @(negedge clk);
    set_rf(32'h6000_0000, 32'h6100_0000, 2'b00, 8'd0, 1'b1, 4'd0, 2'b10, 1'b0);
    @(negedge clk);
    rf_valid = 1'b0;
    #1;
    ck("R11 overflow pulse", {63'h0, fill_ovf}, 1);
    @(negedge clk);
    #1;
    ck("R11 overflow one cycle", {63'h0, fill_ovf}, 0);
    lk(32'h6000_0000, 8'd0, 2'b00, 1'b0, 1, 0, 0, 0, "R11 dropped refill misses");
    lock(7, 1'b0);
    rf(32'h7000_0000, 32'h7100_0000, 2'b00, 8'd0, 1'b1, 4'd0, 2'b10, 1'b0);
    lk(32'h7000_0010, 8'd0, 2'b00, 1'b0, 1, 1, 32'h7100_0010, 2'b00, "R10 refill into free slot");
    begin
      int hits;
      hits = 0;
      for (int k = 0; k < 32; k++) begin
        lk(32'h4000_0000 + (k << 12), 8'd0, 2'b00, 1'b0, 0, 0, 0, 0, "R10 scan");
        if (last_hit) hits++;
      end
      ck("R10 locked entries survive", 64'(hits), 64'd31);
    end
    rf(32'h7800_0000, 32'h7900_0000, 2'b00, 8'd0, 1'b1, 4'd0, 2'b10, 1'b0);
    lk(32'h7000_0010, 8'd0, 2'b00, 1'b0, 1, 0, 0, 0, "R10 same slot reused");
    lk(32'h7800_0010, 8'd0, 2'b00, 1'b0, 1, 1, 32'h7900_0010, 2'b00, "R10 newest refill hits");

    repeat (3) @(negedge clk);
    ck("R1 scoreboard drained", 64'(sbq.size()), 0);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule